// File: doc/BRIEF.md
# Power-Down Clock Stop Controller

This block sits between the free-running clock sources of a multi-output clock generator and its output drivers. When the system asks to power down, it stops every output cleanly: each output is held at a defined level or released to high impedance, and the change happens only on a chosen edge of that output's own source. When the request is removed, it restarts every output without a runt pulse. Output drivers are modelled as a data level plus an output-enable. An enable of 0 means the pin floats.

All logic runs on the sampling clock, which is the complement phase of the CPU differential clock. The source phases are taken in as levels and sampled on that clock. Edges of a source are found by comparing each sample with the one before it, so every output is the registered image of its source, one sampling cycle late. Single-ended clocks park low. Each differential pair parks with its true output high. A per-pair drive-mode bit selects the parked form: true driven high with the complement floating, or both outputs floating. A pair that floated both outputs is driven high again for a set number of cycles after release, before it may toggle. A status output reports when every output is back in normal operation.

Top module: `pd_clock_stop`

## Requirements
- R1: The asynchronous power-down request passes through a two-flop synchronizer. It stops outputs only after the synchronized request has been seen high on QUAL_EDGES (default 2) consecutive sampling edges. A request pulse that covers only one sampling edge stops nothing.
- R2: After reset and while no stop is in force, every output equals its source one sampling cycle later, and all differential output-enables are 1.
- R3: While a stop is in force, a single-ended output goes to 0 at the first high-to-low transition of its source and then stays 0. A high phase that is already in progress is not shortened.
- R4: While a stop is in force, a differential pair freezes at the first high-to-low transition of its complement source, with the true output at 1.
- R5: A frozen pair whose drive-mode bit is 0 drives its true output high (true enable 1) and floats its complement output (complement enable 0).
- R6: A frozen pair whose drive-mode bit is 1 floats both outputs (both enables 0).
- R7: After the stop is lifted, a frozen output changes only on a rising edge of its own true source. Until that edge, single-ended outputs stay 0 and pair true outputs stay 1. An output never changes in a cycle in which its source did not change.
- R8: A pair frozen with drive-mode 1 drives its true output high, with the true enable at 1, no later than 5 sampling cycles after the request input falls.
- R9: A re-driven pair holds true-high with the complement floating for at least REDRIVE_CYC cycles before it resumes toggling.
- R10: all_run is 1 exactly when no stop is in force and every output is in normal operation. When it is 1, all differential enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_samp | input | 1 | Sampling clock (CPU complement phase) |
| rst_n | input | 1 | Active-low reset |
| pd_req | input | 1 | Asynchronous active-high power-down request |
| se_src | input | N_SE | Single-ended source clock levels |
| df_t_src | input | N_DF | Differential true-phase source levels |
| df_c_src | input | N_DF | Differential complement-phase source levels |
| dmode | input | N_DF | Per-pair parked mode: 0 true high / complement floating, 1 both floating |
| se_out | output | N_SE | Single-ended output levels |
| df_t_out | output | N_DF | Pair true output levels |
| df_c_out | output | N_DF | Pair complement output levels |
| df_t_oe | output | N_DF | Pair true output-enable |
| df_c_oe | output | N_DF | Pair complement output-enable |
| all_run | output | 1 | Every output back in normal operation |

## Verification
The bench builds the block with two single-ended lanes and two pairs. Pair 0 is in drive-mode 0 and pair 1 in drive-mode 1, so both parked forms are exercised side by side in one stop. QUAL_EDGES stays at 2, so a one-edge request pulse falls just short of qualification. REDRIVE_CYC is set to 3, which makes the lower and upper bounds of the re-drive hold measurable by toggling the source every cycle.

// File: rtl/pdcs_pkg.sv
package pdcs_pkg;

    // Life cycle of one differential pair
    typedef enum logic [1:0] {
        PAIR_RUN   = 2'd0,
        PAIR_PARK  = 2'd1,
        PAIR_REDRV = 2'd2
    } pair_st_e;

endpackage

// File: rtl/pdcs_req_qual.sv
module pdcs_req_qual #(
    parameter int QUAL_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic stop_o
);
    localparam int CW = $clog2(QUAL_EDGES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          stop;
    } qual_t;

    qual_t q, d;

    always_comb begin
        d    = q;
        d.s1 = req_async;
        d.s2 = q.s1;
        if (!q.s2) begin
            d.cnt  = '0;
            d.stop = 1'b0;
        end else begin
            if (q.cnt != CW'(QUAL_EDGES)) begin
                d.cnt = q.cnt + 1'b1;
            end
            if (q.cnt >= CW'(QUAL_EDGES - 1)) begin
                d.stop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stop_o = q.stop;

endmodule

// File: rtl/pdcs_se_lane.sv
module pdcs_se_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic src_i,
    output logic out_o,
    output logic run_o
);
    typedef struct packed {
        logic prev;
        logic frozen;
        logic out;
    } se_t;

    se_t q, d;
    logic rise, fall;

    always_comb begin
        rise = src_i & ~q.prev;
        fall = ~src_i & q.prev;
        d      = q;
        d.prev = src_i;
        if (q.frozen) begin
            // restart only on a rising source edge: first high is full width
            if (!stop_i && rise) begin
                d.frozen = 1'b0;
            end
        end else if (stop_i && fall) begin
            d.frozen = 1'b1;
        end
        d.out = d.frozen ? 1'b0 : src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_o = q.out;
    assign run_o = ~q.frozen;

endmodule

// File: rtl/pdcs_diff_lane.sv
module pdcs_diff_lane
    import pdcs_pkg::*;
#(
    parameter int REDRIVE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic mode_i,
    input  logic t_src_i,
    input  logic c_src_i,
    output logic t_o,
    output logic c_o,
    output logic t_oe_o,
    output logic c_oe_o,
    output logic run_o
);
    localparam int HW = (REDRIVE_CYC > 1) ? $clog2(REDRIVE_CYC) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(REDRIVE_CYC - 1);

    typedef struct packed {
        pair_st_e      st;
        logic          prev_t;
        logic          prev_c;
        logic [HW-1:0] cnt;
        logic          t;
        logic          c;
        logic          t_oe;
        logic          c_oe;
    } pair_t;

    pair_t q, d;
    logic rise_t, fall_c, hold_done;

    always_comb begin
        rise_t    = t_src_i & ~q.prev_t;
        fall_c    = ~c_src_i & q.prev_c;
        hold_done = (q.cnt >= HOLD_LAST);
        d         = q;
        d.prev_t  = t_src_i;
        d.prev_c  = c_src_i;

        unique case (q.st)
            PAIR_RUN: begin
                if (stop_i && fall_c) begin
                    d.st = PAIR_PARK;
                end
            end
            PAIR_PARK: begin
                if (!stop_i) begin
                    if (mode_i) begin
                        d.st  = PAIR_REDRV;
                        d.cnt = '0;
                    end else if (rise_t) begin
                        d.st = PAIR_RUN;
                    end
                end
            end
            PAIR_REDRV: begin
                if (stop_i) begin
                    d.st = PAIR_PARK;
                end else if (hold_done && rise_t) begin
                    d.st = PAIR_RUN;
                end else if (!hold_done) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = PAIR_RUN;
        endcase

        unique case (d.st)
            PAIR_PARK: begin
                d.t    = 1'b1;
                d.c    = 1'b0;
                d.t_oe = ~mode_i;
                d.c_oe = 1'b0;
            end
            PAIR_REDRV: begin
                d.t    = 1'b1;
                d.c    = 1'b0;
                d.t_oe = 1'b1;
                d.c_oe = 1'b0;
            end
            default: begin
                d.t    = t_src_i;
                d.c    = c_src_i;
                d.t_oe = 1'b1;
                d.c_oe = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= PAIR_RUN;
            q.t_oe <= 1'b1;
            q.c_oe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign t_o    = q.t;
    assign c_o    = q.c;
    assign t_oe_o = q.t_oe;
    assign c_oe_o = q.c_oe;
    assign run_o  = (q.st == PAIR_RUN);

endmodule

// File: rtl/pd_clock_stop.sv
module pd_clock_stop #(
    parameter int N_SE        = 2,
    parameter int N_DF        = 2,
    parameter int QUAL_EDGES  = 2,
    parameter int REDRIVE_CYC = 3
) (
    input  logic            clk_samp,
    input  logic            rst_n,
    input  logic            pd_req,
    input  logic [N_SE-1:0] se_src,
    input  logic [N_DF-1:0] df_t_src,
    input  logic [N_DF-1:0] df_c_src,
    input  logic [N_DF-1:0] dmode,
    output logic [N_SE-1:0] se_out,
    output logic [N_DF-1:0] df_t_out,
    output logic [N_DF-1:0] df_c_out,
    output logic [N_DF-1:0] df_t_oe,
    output logic [N_DF-1:0] df_c_oe,
    output logic            all_run
);
    logic            stop_w;
    logic [N_SE-1:0] se_run;
    logic [N_DF-1:0] df_run;

    pdcs_req_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
        .clk       (clk_samp),
        .rst_n     (rst_n),
        .req_async (pd_req),
        .stop_o    (stop_w)
    );

    for (genvar i = 0; i < N_SE; i++) begin : g_se
        pdcs_se_lane u_lane (
            .clk    (clk_samp),
            .rst_n  (rst_n),
            .stop_i (stop_w),
            .src_i  (se_src[i]),
            .out_o  (se_out[i]),
            .run_o  (se_run[i])
        );
    end

    for (genvar j = 0; j < N_DF; j++) begin : g_df
        pdcs_diff_lane #(.REDRIVE_CYC(REDRIVE_CYC)) u_lane (
            .clk     (clk_samp),
            .rst_n   (rst_n),
            .stop_i  (stop_w),
            .mode_i  (dmode[j]),
            .t_src_i (df_t_src[j]),
            .c_src_i (df_c_src[j]),
            .t_o     (df_t_out[j]),
            .c_o     (df_c_out[j]),
            .t_oe_o  (df_t_oe[j]),
            .c_oe_o  (df_c_oe[j]),
            .run_o   (df_run[j])
        );
    end

    assign all_run = ~stop_w & (&se_run) & (&df_run);

endmodule

// File: rtl/pdcs_checker.sv
module pdcs_checker #(
    parameter int N_SE = 2,
    parameter int N_DF = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pd_req,
    input logic            stop,
    input logic [N_SE-1:0] se_src,
    input logic [N_SE-1:0] se_out,
    input logic [N_DF-1:0] df_t_src,
    input logic [N_DF-1:0] df_t_out,
    input logic [N_DF-1:0] df_t_oe,
    input logic [N_DF-1:0] df_c_oe,
    input logic [N_DF-1:0] dmode,
    input logic            all_run
);
    // Stop may begin only after two sampled-high request edges
    assert_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |-> ($past(pd_req, 3) && $past(pd_req, 4)));

    assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        all_run |-> ((&df_t_oe) && (&df_c_oe)));

    for (genvar i = 0; i < N_SE; i++) begin : g_se_chk
        assert_se_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(se_out[i]) |-> ($past(se_src[i]) != $past(se_src[i], 2)));
    end

    for (genvar j = 0; j < N_DF; j++) begin : g_df_chk
        logic [1:0] late_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                late_q <= '0;
            end else if (!stop && !df_t_oe[j]) begin
                if (late_q != 2'd3) late_q <= late_q + 2'd1;
            end else begin
                late_q <= '0;
            end
        end

        assert_true_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (df_t_oe[j] && !df_c_oe[j]) |-> df_t_out[j]);

        assert_full_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (stop && $past(stop) && dmode[j] && $stable(dmode[j]) && !df_c_oe[j])
            |-> !df_t_oe[j]);

        assert_df_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(df_t_out[j]) |-> ($past(df_t_src[j]) != $past(df_t_src[j], 2)));

        assert_redrive_R8: assert property (@(posedge clk) disable iff (!rst_n)
            late_q < 2'd3);
    end

endmodule

bind pd_clock_stop pdcs_checker #(.N_SE(N_SE), .N_DF(N_DF)) u_chk (
    .clk      (clk_samp),
    .rst_n    (rst_n),
    .pd_req   (pd_req),
    .stop     (stop_w),
    .se_src   (se_src),
    .se_out   (se_out),
    .df_t_src (df_t_src),
    .df_t_out (df_t_out),
    .df_t_oe  (df_t_oe),
    .df_c_oe  (df_c_oe),
    .dmode    (dmode),
    .all_run  (all_run)
);

// File: tb/pd_clock_stop_bench.sv
module pd_clock_stop_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_SE = 2;
    localparam int N_DF = 2;
    localparam int RCYC = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pd_req = 1'b0;
    logic [N_SE-1:0] se_src = '0;
    logic [N_DF-1:0] df_t_src = '0;
    logic [N_DF-1:0] df_c_src;
    logic [N_DF-1:0] dmode = '0;
    logic [N_SE-1:0] se_out;
    logic [N_DF-1:0] df_t_out, df_c_out, df_t_oe, df_c_oe;
    logic            all_run;

    int n_chk = 0;
    int n_fail = 0;

    assign df_c_src = ~df_t_src;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pd_clock_stop #(
        .N_SE(N_SE), .N_DF(N_DF), .QUAL_EDGES(2), .REDRIVE_CYC(RCYC)
    ) u_pd_clock_stop (
        .clk_samp (clk),
        .rst_n    (rst_n),
        .pd_req   (pd_req),
        .se_src   (se_src),
        .df_t_src (df_t_src),
        .df_c_src (df_c_src),
        .dmode    (dmode),
        .se_out   (se_out),
        .df_t_out (df_t_out),
        .df_c_out (df_c_out),
        .df_t_oe  (df_t_oe),
        .df_c_oe  (df_c_oe),
        .all_run  (all_run)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        tick();
        chk("R2 reset se_out", 32'(se_out), 0);
        chk("R2 reset df_t_out", 32'(df_t_out), 0);
        chk("R2 reset true oe", 32'(df_t_oe), 3);
        chk("R2 reset comp oe", 32'(df_c_oe), 3);
        chk("R10 reset all_run", 32'(all_run), 1);
    endtask

    task automatic t_follow();
        for (int k = 0; k < 8; k++) begin
            se_src   = 2'(k);
            df_t_src = 2'(k >> 1);
            tick();
            chk("R2 se follows", 32'(se_out), 32'(se_src));
            chk("R2 true follows", 32'(df_t_out), 32'(df_t_src));
            chk("R2 comp follows", 32'(df_c_out), 32'(df_c_src));
        end
    endtask

    task automatic t_short_req();
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick();
            chk("R1 one-edge pulse ignored", 32'(all_run), 1);
        end
    endtask

    task automatic t_stop();
        int seen;
        dmode    = 2'b10;
        se_src   = 2'b11;
        df_t_src = 2'b00;
        tick();
        pd_req = 1'b1;
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            tick();
            if (!all_run) begin
                seen = 1;
                break;
            end
        end
        chk("R1 qualified request stops", 32'(seen), 1);
        tick();
        chk("R3 high phase not cut", 32'(se_out), 3);
        chk("R4 pair waits for comp fall", 32'(df_t_out), 0);
        chk("R4 pair still driven", 32'(df_c_oe), 3);
        se_src   = 2'b00;
        df_t_src = 2'b11;
        tick();
        chk("R3 se frozen low", 32'(se_out), 0);
        chk("R4 true parked high", 32'(df_t_out), 3);
        chk("R5 R6 true enables", 32'(df_t_oe), 1);
        chk("R5 comp floats", 32'(df_c_oe), 0);
        for (int k = 0; k < 6; k++) begin
            se_src   = ~se_src;
            df_t_src = ~df_t_src;
            tick();
            chk("R3 se stays low", 32'(se_out), 0);
            chk("R4 true stays high", 32'(df_t_out), 3);
            chk("R6 mode1 both float", 32'({df_t_oe[1], df_c_oe[1]}), 0);
            chk("R5 mode0 true driven", 32'({df_t_oe[0], df_c_oe[0]}), 2);
        end
    endtask

    task automatic t_release();
        int n;
        se_src   = 2'b11;
        df_t_src = 2'b11;
        tick();
        pd_req = 1'b0;
        n = 99;
        for (int k = 1; k <= 6; k++) begin
            tick();
            chk("R7 se holds low on release", 32'(se_out), 0);
            if (df_t_oe[1]) begin
                n = k;
                break;
            end
        end
        chk("R8 re-drive within bound", 32'(n <= 5), 1);
        for (int k = 0; k < RCYC + 2; k++) begin
            tick();
            chk("R7 no restart without edge se", 32'(se_out), 0);
            chk("R7 no restart comp oe", 32'(df_c_oe), 0);
            chk("R7 true held high", 32'(df_t_out), 3);
            chk("R10 not all running", 32'(all_run), 0);
        end
        se_src   = 2'b00;
        df_t_src = 2'b00;
        tick();
        chk("R7 se low phase", 32'(se_out), 0);
        chk("R7 true stays high until rise", 32'(df_t_out), 3);
        se_src   = 2'b11;
        df_t_src = 2'b11;
        tick();
        chk("R7 se resumes on rise", 32'(se_out), 3);
        chk("R7 true resumes", 32'(df_t_out), 3);
        chk("R7 true oe back", 32'(df_t_oe), 3);
        chk("R7 comp oe back", 32'(df_c_oe), 3);
        chk("R10 all running again", 32'(all_run), 1);
    endtask

    task automatic t_hold();
        int cnt;
        dmode    = 2'b10;
        se_src   = 2'b00;
        df_t_src = 2'b00;
        tick();
        pd_req = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick();
            if (!all_run) break;
        end
        df_t_src = 2'b11;
        tick();
        chk("R6 pair1 floats", 32'(df_t_oe[1]), 0);
        pd_req = 1'b0;
        for (int k = 0; k < 8; k++) begin
            df_t_src = ~df_t_src;
            tick();
            if (df_t_oe[1]) break;
        end
        chk("R8 pair1 re-driven", 32'(df_t_oe[1]), 1);
        cnt = 1;
        for (int k = 0; k < 20; k++) begin
            df_t_src = ~df_t_src;
            tick();
            if (df_c_oe[1]) break;
            cnt++;
        end
        chk("R9 hold lower bound", 32'(cnt >= RCYC), 1);
        chk("R9 hold upper bound", 32'(cnt <= RCYC + 1), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_follow();
        t_short_req();
        t_stop();
        t_release();
        t_hold();
        repeat (4) tick();
        t_follow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule